// File: doc/BRIEF.md
# Cache Miss Reservation Table

This block sits beside a pipelined cache bank. It keeps core requests that missed until the memory line they need comes back, and then sends them back into the bank pipeline in their original order. Entries are held in a circular buffer. A new miss is written at the tail. A replay pointer walks forward and presents the next waiting entry. A resolve pointer follows the replays as they come out of the end of the bank pipeline. An entry keeps its slot after it is issued. It leaves the table only when its replay comes back as a hit. If the replay misses again, the entry is re-armed in the same slot.

The bank talks to the table through five ports:
- **Enqueue.** Writes a new miss, or re-arms a replay that missed again. Each entry carries its line address, an opaque payload (write word, thread id, tag, read/write flag, byte enables, word select) and a ready flag. The ready flag is set on entry when the line is already on its way.
- **Fill notify.** Makes every waiting entry for a returned line eligible for replay.
- **Lookup.** Tells the pipeline front whether a line still has requests parked here, so that younger requests to that line can be forced to miss.
- **Replay.** A valid/ready pair. `deq_valid` offers the entry and `deq_sched` takes it. The bank holds `deq_sched` low to stall replay. While `deq_sched` is low the offered line and payload do not change, unless a re-arm in that same cycle rewinds the replay pointer.
- **Retire.** Frees the oldest entry.

Top module: `miss_resv_table`

## Requirements
- R1: After reset, `deq_valid`, `full` and `look_hazard` are all 0.
- R2: An enqueue with `enq_replay`=0, accepted while not full, puts the line, the payload and the ready flag (`enq_ready_init`) into the slot after the youngest entry. An entry that is not ready is never offered on the replay port.
- R3: A fill notice makes every valid entry whose line equals `fill_line` ready from the next cycle on. A new entry enqueued in the same cycle as a fill for its own line starts ready, even if `enq_ready_init` is 0.
- R4: `look_hazard` is 1 in the same cycle whenever any valid entry, issued or not, holds the line `look_line`. Otherwise it is 0.
- R5: The replay port offers only the oldest entry not yet issued, with its stored line and payload. A younger ready entry never passes an older one that is not ready. While the offer is not taken, and no re-arm happens in that cycle, the offered line and payload stay stable.
- R6: An entry is issued in a cycle with `deq_valid`=1 and `deq_sched`=1. The next cycle offers the following entry, and the issued entry still occupies its slot.
- R7: While `issue_hold` is 1, `deq_valid` is 0.
- R8: A `retire` pulse frees the oldest entry. A table that was full and gets no new entry in that cycle is no longer full in the next cycle.
- R9: An enqueue with `enq_replay`=1 resolves the oldest in-flight replay as a miss. The entry stays in its slot, takes the new payload, and becomes ready according to `enq_ready_init` or a same-cycle fill for its line. Replay rewinds to that entry. Nothing is offered until every earlier replay still in flight has resolved. `retire` and a re-arm never occur in the same cycle.
- R10: `full` is 1 exactly when DEPTH entries (a power of two, at least 2) are occupied. A new enqueue is never presented while `full` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_valid | input | 1 | Enqueue strobe |
| enq_replay | input | 1 | 1: re-arm the oldest in-flight replay; 0: new entry |
| enq_line | input | ADDR_W | Line address of a new entry |
| enq_payload | input | PAY_W | Request payload |
| enq_ready_init | input | 1 | Entry starts ready |
| fill_valid | input | 1 | Fill for a line is being taken |
| fill_line | input | ADDR_W | Line address of the fill |
| look_line | input | ADDR_W | Line at the pipeline front |
| look_hazard | output | 1 | A valid entry holds look_line |
| deq_valid | output | 1 | Replay entry offered |
| deq_sched | input | 1 | Replay entry taken |
| deq_line | output | ADDR_W | Line of the offered entry |
| deq_payload | output | PAY_W | Payload of the offered entry |
| issue_hold | input | 1 | Earlier replay missing in a later stage |
| retire | input | 1 | Oldest entry replayed as a hit; free it |
| full | output | 1 | All slots occupied |

## Verification
The hardest situation to reach is the rewind. A replay misses again while younger replays are still in flight. The table must then resolve those younger replays as re-arms, step back to the first one, and hold off issuing until everything in flight has drained. The directed part of the bench creates one rewind on purpose. The random part issues often and sends a replay back as a miss about a quarter of the time. Once a rewind has started, it forces every later resolution to be a re-arm. Because only four line addresses are used, fills, lookups and same-cycle fill-plus-enqueue collisions keep landing on occupied lines.

// File: rtl/mrt_pkg.sv
package mrt_pkg;
  typedef enum logic [1:0] {
    RES_NONE   = 2'd0,
    RES_RETIRE = 2'd1,
    RES_REARM  = 2'd2
  } res_kind_e;
endpackage

// File: rtl/mrt_store.sv
module mrt_store #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 26,
  parameter int PAY_W  = 48,
  localparam int IW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_en,
  input  logic [IW-1:0]     alloc_idx,
  input  logic              rearm_en,
  input  logic [IW-1:0]     rearm_idx,
  input  logic              free_en,
  input  logic [IW-1:0]     free_idx,
  input  logic [ADDR_W-1:0] w_line,
  input  logic [PAY_W-1:0]  w_pay,
  input  logic              w_rdy,
  input  logic              fill_en,
  input  logic [ADDR_W-1:0] fill_line,
  input  logic [ADDR_W-1:0] look_line,
  input  logic [IW-1:0]     rd_idx,
  output logic              rd_valid,
  output logic              rd_ready,
  output logic [ADDR_W-1:0] rd_line,
  output logic [PAY_W-1:0]  rd_pay,
  output logic              look_hit
);
  logic [DEPTH-1:0]  v_q, r_q;
  logic [ADDR_W-1:0] line_q [DEPTH];
  logic [PAY_W-1:0]  pay_q  [DEPTH];
  logic [DEPTH-1:0]  fill_hit, look_match;
  logic              fill_new;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign fill_hit[g]   = fill_en && v_q[g] && (line_q[g] == fill_line);
    assign look_match[g] = v_q[g] && (line_q[g] == look_line);
  end

  assign fill_new = fill_en && (fill_line == w_line);
  assign look_hit = |look_match;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q <= '0;
      r_q <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (free_en && free_idx == IW'(i)) begin
          v_q[i] <= 1'b0;
          r_q[i] <= 1'b0;
        end else if (alloc_en && alloc_idx == IW'(i)) begin
          v_q[i] <= 1'b1;
          r_q[i] <= w_rdy | fill_new;
        end else if (rearm_en && rearm_idx == IW'(i)) begin
          r_q[i] <= w_rdy | fill_hit[i];
        end else if (fill_hit[i]) begin
          r_q[i] <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (alloc_en && alloc_idx == IW'(i)) begin
        line_q[i] <= w_line;
        pay_q[i]  <= w_pay;
      end else if (rearm_en && rearm_idx == IW'(i)) begin
        pay_q[i]  <= w_pay;
      end
    end
  end

  assign rd_valid = v_q[rd_idx];
  assign rd_ready = r_q[rd_idx];
  assign rd_line  = line_q[rd_idx];
  assign rd_pay   = pay_q[rd_idx];
endmodule

// File: rtl/mrt_ctrl.sv
module mrt_ctrl
  import mrt_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int IW   = $clog2(DEPTH),
  localparam int PW   = IW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc,
  input  logic          sched,
  input  logic          hold,
  input  res_kind_e     res_kind,
  input  logic          rd_valid,
  input  logic          rd_ready,
  output logic          deq_valid,
  output logic          full,
  output logic [IW-1:0] head_idx,
  output logic [IW-1:0] tail_idx,
  output logic [IW-1:0] iss_idx,
  output logic [IW-1:0] res_idx
);
  localparam logic [PW-1:0] CAP = PW'(DEPTH);

  logic [PW-1:0] head_q, tail_q, iss_q, res_q, infl_q;
  logic          rewound_q;
  logic          issue, drain_wait, resolve;

  assign drain_wait = rewound_q && (infl_q != '0);
  assign deq_valid  = (tail_q != iss_q) && rd_valid && rd_ready && !hold && !drain_wait;
  assign issue      = deq_valid && sched;
  assign full       = (PW'(tail_q - head_q) == CAP);
  assign resolve    = (res_kind != RES_NONE);

  assign head_idx = head_q[IW-1:0];
  assign tail_idx = tail_q[IW-1:0];
  assign iss_idx  = iss_q[IW-1:0];
  assign res_idx  = res_q[IW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q    <= '0;
      tail_q    <= '0;
      iss_q     <= '0;
      res_q     <= '0;
      infl_q    <= '0;
      rewound_q <= 1'b0;
    end else begin
      if (alloc) tail_q <= tail_q + 1'b1;

      case ({issue, resolve})
        2'b10:   infl_q <= infl_q + 1'b1;
        2'b01:   infl_q <= infl_q - 1'b1;
        default: infl_q <= infl_q;
      endcase

      if (res_kind == RES_REARM && !rewound_q) begin
        iss_q     <= res_q;
        rewound_q <= 1'b1;
      end else if (issue) begin
        iss_q <= iss_q + 1'b1;
        if (rewound_q) rewound_q <= 1'b0;
      end

      if (res_kind == RES_REARM) begin
        res_q <= res_q + 1'b1;
      end else if (res_kind == RES_RETIRE) begin
        res_q  <= res_q + 1'b1;
        head_q <= head_q + 1'b1;
      end else if (issue && rewound_q) begin
        res_q <= iss_q;
      end
    end
  end
endmodule

// File: rtl/miss_resv_table.sv
module miss_resv_table
  import mrt_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 26,
  parameter int PAY_W  = 48,
  localparam int IW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enq_valid,
  input  logic              enq_replay,
  input  logic [ADDR_W-1:0] enq_line,
  input  logic [PAY_W-1:0]  enq_payload,
  input  logic              enq_ready_init,
  input  logic              fill_valid,
  input  logic [ADDR_W-1:0] fill_line,
  input  logic [ADDR_W-1:0] look_line,
  output logic              look_hazard,
  output logic              deq_valid,
  input  logic              deq_sched,
  output logic [ADDR_W-1:0] deq_line,
  output logic [PAY_W-1:0]  deq_payload,
  input  logic              issue_hold,
  input  logic              retire,
  output logic              full
);
  logic          alloc, rearm, rd_valid, rd_ready;
  logic [IW-1:0] head_idx, tail_idx, iss_idx, res_idx;
  res_kind_e     res_kind;

  assign alloc    = enq_valid && !enq_replay && !full;
  assign rearm    = enq_valid && enq_replay;
  assign res_kind = rearm ? RES_REARM : (retire ? RES_RETIRE : RES_NONE);

  mrt_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .alloc     (alloc),
    .sched     (deq_sched),
    .hold      (issue_hold),
    .res_kind  (res_kind),
    .rd_valid  (rd_valid),
    .rd_ready  (rd_ready),
    .deq_valid (deq_valid),
    .full      (full),
    .head_idx  (head_idx),
    .tail_idx  (tail_idx),
    .iss_idx   (iss_idx),
    .res_idx   (res_idx)
  );

  mrt_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .PAY_W(PAY_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .alloc_en  (alloc),
    .alloc_idx (tail_idx),
    .rearm_en  (rearm),
    .rearm_idx (res_idx),
    .free_en   (res_kind == RES_RETIRE),
    .free_idx  (head_idx),
    .w_line    (enq_line),
    .w_pay     (enq_payload),
    .w_rdy     (enq_ready_init),
    .fill_en   (fill_valid),
    .fill_line (fill_line),
    .look_line (look_line),
    .rd_idx    (iss_idx),
    .rd_valid  (rd_valid),
    .rd_ready  (rd_ready),
    .rd_line   (deq_line),
    .rd_pay    (deq_payload),
    .look_hit  (look_hazard)
  );
endmodule

// File: rtl/mrt_chk.sv
module mrt_chk #(
  parameter int ADDR_W = 26,
  parameter int PAY_W  = 48
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enq_valid,
  input logic              enq_replay,
  input logic              deq_valid,
  input logic              deq_sched,
  input logic [ADDR_W-1:0] deq_line,
  input logic [PAY_W-1:0]  deq_payload,
  input logic              issue_hold,
  input logic              retire,
  input logic              full
);
  // R10
  no_enq_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enq_valid && !enq_replay) |-> !full);

  // R7
  hold_blocks_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_hold |-> !deq_valid);

  // R5
  offer_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (deq_valid && !deq_sched && !(enq_valid && enq_replay))
      |=> ($stable(deq_line) && $stable(deq_payload)));

  // R8
  retire_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && !(enq_valid && !enq_replay)) |=> !full);

  // R9
  retire_rearm_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    retire |-> !(enq_valid && enq_replay));
endmodule

bind miss_resv_table mrt_chk #(.ADDR_W(ADDR_W), .PAY_W(PAY_W)) u_mrt_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .enq_valid   (enq_valid),
  .enq_replay  (enq_replay),
  .deq_valid   (deq_valid),
  .deq_sched   (deq_sched),
  .deq_line    (deq_line),
  .deq_payload (deq_payload),
  .issue_hold  (issue_hold),
  .retire      (retire),
  .full        (full)
);

// File: tb/tb_miss_resv_table.sv
module tb_miss_resv_table;
  localparam int D  = 8;
  localparam int AW = 26;
  localparam int PW = 48;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enq_valid = 0, enq_replay = 0, enq_ready_init = 0;
  logic [AW-1:0] enq_line = '0, fill_line = '0, look_line = '0;
  logic [PW-1:0] enq_payload = '0;
  logic fill_valid = 0, deq_sched = 0, issue_hold = 0, retire = 0;
  logic look_hazard, deq_valid, full;
  logic [AW-1:0] deq_line;
  logic [PW-1:0] deq_payload;

  always #5 clk = ~clk;

  miss_resv_table #(.DEPTH(D), .ADDR_W(AW), .PAY_W(PW)) dut (
    .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_replay(enq_replay),
    .enq_line(enq_line), .enq_payload(enq_payload), .enq_ready_init(enq_ready_init),
    .fill_valid(fill_valid), .fill_line(fill_line), .look_line(look_line),
    .look_hazard(look_hazard), .deq_valid(deq_valid), .deq_sched(deq_sched),
    .deq_line(deq_line), .deq_payload(deq_payload), .issue_hold(issue_hold),
    .retire(retire), .full(full)
  );

  int n_tests = 0, n_fail = 0;

  // reference state
  bit            m_v [D];
  bit            m_r [D];
  logic [AW-1:0] m_a [D];
  logic [PW-1:0] m_p [D];
  int m_head = 0, m_tail = 0, m_iss = 0, m_res = 0, m_infl = 0;
  bit m_rew = 0;

  function automatic logic [AW-1:0] ln(int k);
    return AW'(32'h100 + k);
  endfunction

  function automatic bit exp_full();
    return (m_tail - m_head) == D;
  endfunction

  function automatic bit exp_dv(bit hd);
    int i = m_iss % D;
    return (m_tail > m_iss) && m_v[i] && m_r[i] && !hd && !(m_rew && m_infl != 0);
  endfunction

  function automatic bit exp_haz(logic [AW-1:0] la);
    for (int i = 0; i < D; i++) if (m_v[i] && m_a[i] == la) return 1'b1;
    return 1'b0;
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(bit ev, bit er, logic [AW-1:0] ea, logic [PW-1:0] ep, bit ei,
                     bit fv, logic [AW-1:0] fa, bit sc, bit hd, bit rt, logic [AW-1:0] la);
    bit dv, iss, alloc, rearm, ret;
    bit hit [D];
    int k;
    @(negedge clk);
    enq_valid = ev; enq_replay = er; enq_line = ea; enq_payload = ep; enq_ready_init = ei;
    fill_valid = fv; fill_line = fa; deq_sched = sc; issue_hold = hd; retire = rt; look_line = la;
    #1;
    dv = exp_dv(hd);
    chk(deq_valid == dv, "R5 deq_valid", 64'(deq_valid), 64'(dv));
    if (dv) begin
      chk(deq_line == m_a[m_iss % D], "R5 deq_line", 64'(deq_line), 64'(m_a[m_iss % D]));
      chk(deq_payload == m_p[m_iss % D], "R5 deq_payload", 64'(deq_payload), 64'(m_p[m_iss % D]));
    end
    chk(look_hazard == exp_haz(la), "R4 look_hazard", 64'(look_hazard), 64'(exp_haz(la)));
    chk(full == exp_full(), "R10 full", 64'(full), 64'(exp_full()));
    // next state
    iss   = dv && sc;
    alloc = ev && !er && !exp_full();
    rearm = ev && er;
    ret   = rt && !rearm;
    for (int i = 0; i < D; i++) hit[i] = fv && m_v[i] && (m_a[i] == fa);
    for (int i = 0; i < D; i++) if (hit[i]) m_r[i] = 1'b1;
    if (alloc) begin
      k = m_tail % D;
      m_v[k] = 1; m_a[k] = ea; m_p[k] = ep; m_r[k] = ei | (fv && fa == ea);
    end
    if (rearm) begin
      k = m_res % D;
      m_p[k] = ep; m_r[k] = ei | hit[k];
    end
    if (ret) begin
      k = m_head % D;
      m_v[k] = 0; m_r[k] = 0;
    end
    m_infl = m_infl + int'(iss) - int'(rearm || ret);
    if (alloc) m_tail++;
    if (rearm && !m_rew) begin
      m_iss = m_res; m_rew = 1;
    end else if (iss) begin
      if (m_rew) begin m_res = m_iss; m_rew = 0; end
      m_iss++;
    end
    if (rearm) m_res++;
    else if (ret) begin m_res++; m_head++; end
  endtask

  task automatic idle();
    cyc(0, 0, '0, '0, 0, 0, '0, 0, 0, 0, ln(0));
  endtask

  bit done = 0;

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    chk(deq_valid == 0, "R1 deq_valid", 64'(deq_valid), 0);
    chk(full == 0, "R1 full", 64'(full), 0);
    chk(look_hazard == 0, "R1 look_hazard", 64'(look_hazard), 0);
    rst_n = 1'b1;

    // R2: new entry not ready is not offered
    cyc(1, 0, ln(0), 48'hA0, 0, 0, '0, 0, 0, 0, ln(0));
    idle();
    chk(deq_valid == 0, "R2 not ready held", 64'(deq_valid), 0);
    chk(look_hazard == 1, "R4 hazard on parked line", 64'(look_hazard), 1);
    // R3 fill on another line does nothing, fill on its line makes it ready
    cyc(0, 0, '0, '0, 0, 1, ln(3), 0, 0, 0, ln(1));
    chk(deq_valid == 0, "R3 unrelated fill", 64'(deq_valid), 0);
    cyc(0, 0, '0, '0, 0, 1, ln(0), 0, 0, 0, ln(0));
    idle();
    chk(deq_valid == 1 && deq_line == ln(0), "R3 fill ready", 64'(deq_line), 64'(ln(0)));
    // R3 same-cycle fill and enqueue of line 1
    cyc(1, 0, ln(1), 48'hB1, 0, 1, ln(1), 0, 0, 0, ln(1));
    // R7 hold
    cyc(0, 0, '0, '0, 0, 0, '0, 1, 1, 0, ln(0));
    // R6 issue line 0, next offer is line 1 (ready from same-cycle fill)
    cyc(0, 0, '0, '0, 0, 0, '0, 1, 0, 0, ln(0));
    idle();
    chk(deq_valid == 1 && deq_line == ln(1), "R6 next offered / R3 same-cycle", 64'(deq_line), 64'(ln(1)));
    chk(look_hazard == 1, "R6 issued entry still held", 64'(look_hazard), 1);
    // R9 re-arm line 0 not ready: rewinds, nothing offered
    cyc(1, 1, ln(0), 48'hA2, 0, 0, '0, 0, 0, 0, ln(0));
    idle();
    chk(deq_valid == 0, "R9 rewind to unready", 64'(deq_valid), 0);
    cyc(0, 0, '0, '0, 0, 1, ln(0), 0, 0, 0, ln(0));
    idle();
    chk(deq_valid == 1 && deq_payload == 48'hA2, "R9 re-armed payload", 64'(deq_payload), 64'h A2);
    // issue and retire both entries
    cyc(0, 0, '0, '0, 0, 0, '0, 1, 0, 0, ln(0));
    cyc(0, 0, '0, '0, 0, 0, '0, 1, 0, 1, ln(0));
    cyc(0, 0, '0, '0, 0, 0, '0, 0, 0, 1, ln(1));
    idle();
    chk(look_hazard == 0, "R8 all retired", 64'(look_hazard), 0);
    // R10 fill up
    for (int i = 0; i < D; i++) cyc(1, 0, ln(i % 4), PW'(i), 1, 0, '0, 0, 0, 0, ln(0));
    idle();
    chk(full == 1, "R10 full at capacity", 64'(full), 1);
    cyc(0, 0, '0, '0, 0, 0, '0, 1, 0, 0, ln(0));
    cyc(0, 0, '0, '0, 0, 0, '0, 0, 0, 1, ln(0));
    idle();
    chk(full == 0, "R8 retire frees slot", 64'(full), 0);

    // random phase
    for (int n = 0; n < 3000; n++) begin
      bit ev, er, ei, fv, sc, hd, rt;
      logic [AW-1:0] ea, fa, la;
      logic [PW-1:0] ep;
      ev = 0; er = 0; rt = 0;
      hd = ($urandom % 10) == 0;
      sc = ($urandom % 2) == 0;
      fv = ($urandom % 4) == 0;
      fa = ln($urandom % 4);
      la = ln($urandom % 4);
      ea = ln($urandom % 4);
      ep = {$urandom, $urandom} & {PW{1'b1}};
      ei = ($urandom % 4) == 0;
      if (m_infl > 0 && ($urandom % 3) == 0) begin
        if (m_rew || ($urandom % 4) == 0) begin ev = 1; er = 1; end
        else rt = 1;
      end
      if (!er && (m_tail - m_head) < D && ($urandom % 2) == 0) ev = 1;
      cyc(ev, er, ea, ep, ei, fv, fa, sc, hd, rt, la);
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule